// File: doc/BRIEF.md
# Serial-In Shift Register with Latched Parallel Outputs

This block collects a serial bit stream in a chain of shift stages and, on command, copies the whole chain into a separate holding register that drives a parallel output word. Shifting and capture run from two independent strobes. Each strobe is sampled on a common system clock and acts once, on its rising edge. A cascade output carries the last shift stage, so several copies can be chained into one longer register.

A clear input acts asynchronously and empties only the shift stages. The holding register keeps its value through a clear. Shifting resumes only after the clear release has passed through a short synchroniser. The high-impedance state of the parallel outputs is modelled as a data word plus a drive-enable flag. A separate synchronous system reset brings every register to zero.

Top module: `shreg_latch`

## Requirements
- R1: On each accepted rising edge of `shift_clk`, `ser_in` enters stage 0 and every stage n moves to stage n+1.
- R2: `cascade_out` always shows the last shift stage. After a shift, it shows what the second-to-last stage held before that shift.
- R3: While `clear_n` is low, all shift stages are zero, with no clock edge needed. A clear leaves `par_data` unchanged.
- R4: A rising edge of `store_clk` copies all shift stages into the holding register, and `par_data` shows that value from the next cycle.
- R5: When `shift_clk` and `store_clk` rise in the same cycle, the holding register receives the contents from before the shift, and the shift still takes place.
- R6: A `store_clk` rising edge while `clear_n` is low loads all zeros into the holding register.
- R7: `par_oe` is the inverse of `out_en_n`, so the parallel outputs are undriven while `out_en_n` is high. `cascade_out` and the held value are not affected by `out_en_n`.
- R8: `par_data[n]` is holding bit n. Bit 0 is the stage nearest `ser_in`, so the first of WIDTH shifted bits ends at bit WIDTH-1.
- R9: After `clear_n` rises, rising edges of `shift_clk` at the first SYNC_STAGES clock edges are ignored.
- R10: A strobe held high acts only once. Each action needs a new low-to-high change.
- R11: A low `rst_n` at a clock edge clears the shift stages, the holding register and the strobe history.
- R12: Two instances chained through `cascade_out` into `ser_in` behave as one 2×WIDTH-bit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| shift_clk | input | 1 | Shift strobe, acts on its rising edge |
| store_clk | input | 1 | Capture strobe, acts on its rising edge |
| clear_n | input | 1 | Asynchronous active-low clear of the shift stages |
| out_en_n | input | 1 | Active-low parallel output enable |
| ser_in | input | 1 | Serial data input |
| par_data | output | WIDTH | Holding register contents |
| par_oe | output | 1 | High when `par_data` is driven |
| cascade_out | output | 1 | Last shift stage, used for chaining |

## Verification
The hardest situation to reach is the window just after the clear is released. There, a strobe edge must be rejected even though the clear input is already high. The bench releases the clear on a falling clock edge and raises the shift strobe one cycle later, so that the edge lands inside the synchroniser window. It then sends an accepted edge and captures the result: the two possible outcomes differ in bit 1.

A coincident shift and store is also hard to observe, because the effect of the shift is hidden until a later capture. The bench fills the stages without storing, issues both strobes together, and then stores alone, so the pre-shift and post-shift words both reach the outputs.

// File: rtl/shreg_latch_pkg.sv
// Package: shared defaults and the strobe bundle for the shift/latch block.
// Assumes: consumers import it before declaring their ports.
package shreg_latch_pkg;
    parameter int unsigned DEF_WIDTH       = 8;
    parameter int unsigned DEF_SYNC_STAGES = 2;

    localparam int unsigned STROBE_CNT = 2;
    localparam int unsigned IDX_SHIFT  = 0;
    localparam int unsigned IDX_STORE  = 1;

    // Strobe actions for one clock cycle.
    typedef struct packed {
        logic store_go;
        logic shift_go;
    } strobe_t;
endpackage

// File: rtl/shreg_rise_det.sv
// Module: shreg_rise_det
// Detects a low-to-high change on each of N level inputs that are sampled on
// clk. The output pulse is combinational from the input and lasts one cycle.
// Assumes: the inputs are synchronous to clk; rst_n is synchronous.
module shreg_rise_det #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_det
        // Remember last cycle's level of strobe i.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lvl[i];
        end

        // Pulse when strobe i is high now and was low before.
        assign rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/shreg_clr_sync.sv
// Module: shreg_clr_sync
// Produces run_ok, which drops at once when clear_n goes low and rises only
// STAGES clock edges after clear_n returns high.
// Assumes: STAGES >= 1; rst_n is synchronous and also forces run_ok low.
module shreg_clr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_n,
    output logic run_ok
);
    logic [STAGES-1:0] sync_q;

    if (STAGES == 1) begin : g_one
        // Single-stage release flop.
        always_ff @(posedge clk or negedge clear_n) begin
            if (!clear_n)   sync_q <= '0;
            else if (!rst_n) sync_q <= '0;
            else            sync_q <= 1'b1;
        end
    end else begin : g_many
        // Shift a one through the release chain.
        always_ff @(posedge clk or negedge clear_n) begin
            if (!clear_n)   sync_q <= '0;
            else if (!rst_n) sync_q <= '0;
            else            sync_q <= {sync_q[STAGES-2:0], 1'b1};
        end
    end

    assign run_ok = sync_q[STAGES-1];
endmodule

// File: rtl/shreg_chain.sv
// Module: shreg_chain
// WIDTH shift stages. Stage 0 takes ser_in on advance. Stages are cleared
// asynchronously by clear_n and synchronously by rst_n.
// Assumes: advance is a single-cycle pulse that is already qualified.
module shreg_chain #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_n,
    input  logic             advance,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stage_q
);
    logic [WIDTH-1:0] stage_nx;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign stage_nx[i] = ser_in;
        end else begin : g_body
            assign stage_nx[i] = stage_q[i-1];
        end
    end

    // Stage register: async clear, sync reset, shift on advance.
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n)    stage_q <= '0;
        else if (!rst_n) stage_q <= '0;
        else if (advance) stage_q <= stage_nx;
    end
endmodule

// File: rtl/shreg_hold.sv
// Module: shreg_hold
// Holding register loaded from the shift stages on capture. It is cleared only
// by the synchronous system reset, never by the shift clear.
// Assumes: capture is a single-cycle pulse.
module shreg_hold #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Load the pre-edge shift contents on capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (capture) q <= d;
    end
endmodule

// File: rtl/shreg_latch.sv
// Module: shreg_latch (top)
// Serial-in shift register with a separately strobed holding register,
// an output-enable flag and a cascade output.
// Assumes: shift_clk, store_clk, ser_in and out_en_n are synchronous to clk;
// clear_n may change at any time.
module shreg_latch
    import shreg_latch_pkg::*;
#(
    parameter int unsigned WIDTH       = DEF_WIDTH,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_clk,
    input  logic             store_clk,
    input  logic             clear_n,
    input  logic             out_en_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] par_data,
    output logic             par_oe,
    output logic             cascade_out
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [STROBE_CNT-1:0] lvl;
    logic [STROBE_CNT-1:0] rise;
    logic                  run_ok;
    strobe_t               act;
    logic                  shift_go;
    logic                  store_go;
    logic [WIDTH-1:0]      stage_q;

    assign lvl[IDX_SHIFT] = shift_clk;
    assign lvl[IDX_STORE] = store_clk;

    shreg_rise_det #(.N(STROBE_CNT)) u_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .rise (rise)
    );

    shreg_clr_sync #(.STAGES(SYNC_STAGES)) u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_n(clear_n),
        .run_ok (run_ok)
    );

    // Qualify the strobe edges: a shift waits for the clear release.
    always_comb begin
        act.shift_go = rise[IDX_SHIFT] & run_ok;
        act.store_go = rise[IDX_STORE];
    end

    assign shift_go = act.shift_go;
    assign store_go = act.store_go;

    shreg_chain #(.WIDTH(WIDTH)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_n(clear_n),
        .advance(shift_go),
        .ser_in (ser_in),
        .stage_q(stage_q)
    );

    shreg_hold #(.WIDTH(WIDTH)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(store_go),
        .d      (stage_q),
        .q      (par_data)
    );

    assign par_oe      = ~out_en_n;
    assign cascade_out = stage_q[MSB];
endmodule

// File: rtl/shreg_latch_chk.sv
// Module: shreg_latch_chk
// Property checker attached to every shreg_latch through bind.
module shreg_latch_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_n,
    input logic             shift_go,
    input logic             store_go,
    input logic [WIDTH-1:0] stage_q,
    input logic [WIDTH-1:0] par_data,
    input logic             cascade_out
);
    assert_cascade_R2: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
        shift_go |=> cascade_out == $past(stage_q[WIDTH-2]));

    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |-> stage_q == '0);

    assert_clear_keeps_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_n && !store_go) |=> $stable(par_data));

    assert_store_pre_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |=> par_data == $past(stage_q));

    assert_release_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clear_n) |=> !shift_go);

    assert_single_action_R10: assert property (@(posedge clk) disable iff (!rst_n)
        shift_go |=> !shift_go);
endmodule

bind shreg_latch shreg_latch_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_n    (clear_n),
    .shift_go   (shift_go),
    .store_go   (store_go),
    .stage_q    (stage_q),
    .par_data   (par_data),
    .cascade_out(cascade_out)
);

// File: tb/shreg_latch_tb.sv
module shreg_latch_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_clk = 1'b0, store_clk = 1'b0, clear_n = 1'b1, out_en_n = 1'b0, ser_in = 1'b0;
    logic [W-1:0] lo_data, hi_data;
    logic lo_oe, hi_oe, lo_casc, hi_casc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    shreg_latch #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .store_clk(store_clk),
        .clear_n(clear_n), .out_en_n(out_en_n), .ser_in(ser_in),
        .par_data(lo_data), .par_oe(lo_oe), .cascade_out(lo_casc));

    shreg_latch #(.WIDTH(W)) u_hi (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .store_clk(store_clk),
        .clear_n(clear_n), .out_en_n(out_en_n), .ser_in(lo_casc),
        .par_data(hi_data), .par_oe(hi_oe), .cascade_out(hi_casc));

    localparam int NV = 6;
    localparam logic [15:0] VEC [NV] = '{16'hA5C3, 16'h0001, 16'h8000,
                                          16'hFFFF, 16'h0000, 16'h3C96};

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk); ser_in = b; shift_clk = 1'b1;
        @(negedge clk); shift_clk = 1'b0;
    endtask

    task automatic store_now();
        @(negedge clk); store_clk = 1'b1;
        @(negedge clk); store_clk = 1'b0;
    endtask

    task automatic both_now(input logic b);
        @(negedge clk); ser_in = b; shift_clk = 1'b1; store_clk = 1'b1;
        @(negedge clk); shift_clk = 1'b0; store_clk = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); #1 clear_n = 1'b0;
        @(negedge clk); clear_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset lo", {8'h0, lo_data}, 16'h0);
        check("R11 reset hi", {8'h0, hi_data}, 16'h0);
        check("R11 reset cascade", {15'h0, hi_casc}, 16'h0);

        // R1 R8 R12: chained vector table, first bit sent ends at the top bit
        for (int v = 0; v < NV; v++) begin
            for (int b = 15; b >= 0; b--) shift_bit(VEC[v][b]);
            store_now();
            check("R12 R8 R1 chain word", {hi_data, lo_data}, VEC[v]);
            check("R2 cascade top", {15'h0, hi_casc}, {15'h0, VEC[v][15]});
        end

        // R2: cascade shows previous stage 6 after a shift
        for (int b = 7; b >= 0; b--) shift_bit(b == 6);  // stage6=1, stage7=0
        check("R2 cascade before", {15'h0, lo_casc}, 16'h0);
        shift_bit(1'b0);
        check("R2 cascade after", {15'h0, lo_casc}, 16'h1);

        // R5: coincident shift and store latches pre-shift contents
        for (int b = 7; b >= 0; b--) shift_bit(8'h5A >> b);
        both_now(1'b1);
        check("R5 coincident pre-shift", {8'h0, lo_data}, 16'h005A);
        store_now();
        check("R5 shift also happened", {8'h0, lo_data}, 16'h00B5);

        // R7: enable flag only, data and cascade kept
        for (int b = 7; b >= 0; b--) shift_bit(1'b1);
        store_now();
        @(negedge clk); out_en_n = 1'b1;
        #1;
        check("R7 oe off", {14'h0, hi_oe, lo_oe}, 16'h0);
        check("R7 data kept", {8'h0, lo_data}, 16'h00FF);
        check("R7 cascade kept", {15'h0, lo_casc}, 16'h1);
        @(negedge clk); out_en_n = 1'b0;
        #1;
        check("R7 oe on", {14'h0, hi_oe, lo_oe}, 16'h3);

        // R3: async clear of stages, holding register kept
        @(negedge clk); #1 clear_n = 1'b0;
        #0.5;
        check("R3 async clear cascade", {15'h0, lo_casc}, 16'h0);
        @(negedge clk);
        check("R3 hold kept", {8'h0, lo_data}, 16'h00FF);

        // R6: store during clear loads zeros
        store_now();
        check("R6 store during clear", {8'h0, lo_data}, 16'h0);

        // R9: edges inside the release window are ignored
        @(negedge clk); clear_n = 1'b1;                     // edge e1 follows
        @(negedge clk); ser_in = 1'b1; shift_clk = 1'b1;    // edge e2: ignored
        @(negedge clk); shift_clk = 1'b0;
        @(negedge clk); ser_in = 1'b1; shift_clk = 1'b1;    // accepted
        @(negedge clk); shift_clk = 1'b0;
        store_now();
        check("R9 release window", {8'h0, lo_data}, 16'h0001);

        // R10: a held strobe shifts only once
        do_clear();
        @(negedge clk); ser_in = 1'b1; shift_clk = 1'b1;
        repeat (5) @(negedge clk);
        shift_clk = 1'b0;
        store_now();
        check("R10 held strobe", {8'h0, lo_data}, 16'h0001);
        @(negedge clk); store_clk = 1'b1;
        repeat (3) @(negedge clk);
        shift_bit(1'b0);
        @(negedge clk);
        check("R10 held store", {8'h0, lo_data}, 16'h0001);
        store_clk = 1'b0;
        store_now();
        check("R4 store after shift", {8'h0, lo_data}, 16'h0002);

        // R11: sync reset clears holding register
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R11 reset hold", {hi_data, lo_data}, 16'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule